// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen general registers of a processor core. The upper registers keep one copy per processor mode. Two combinational read ports and one write port always address the registers of the mode that is current. A mode-qualified debug port can reach any mode's copy of any register, whether or not that mode is active.

The core presents its mode code on `mode_i` every cycle. When the code selects a different bank, the block saves the outgoing bank's live upper registers into shadow storage on that clock edge. It then loads the incoming bank's copies. Accesses in the next cycle see the new mode's registers. Mode codes that match no real mode select a dummy bank. In that bank the upper registers read as zero and cannot be written.

Top module: `banked_regfile`

## Requirements
- R1: Mode codes select banks as follows. 0x10, 0x00 and 0x1F select the user bank. 0x11 and 0x01 select the fast-interrupt bank. 0x12 and 0x02 select the interrupt bank. 0x13 and 0x03 select the supervisor bank. 0x17 selects the abort bank and 0x1B the undefined bank. Every other code selects the dummy bank.
- R2: Registers 0–7 and 15 are one set shared by every mode.
- R3: The fast-interrupt bank has its own registers 8–14. The interrupt, supervisor, abort and undefined banks each have their own registers 13 and 14 only. The system code (0x1F) uses the user copies.
- R4: Registers 8–12 seen in the user, interrupt, supervisor, abort and undefined banks are one user set. That set keeps its values across any stay in the fast-interrupt or dummy bank.
- R5: In the dummy bank, registers 8–14 read as zero. Writes to them, from either port, are dropped.
- R6: Read ports are combinational. A read of the register being written in the same cycle returns the old value, and the new value is visible from the next cycle.
- R7: A write in the same cycle as a mode change goes to the register set of the old mode.
- R8: The debug port addresses the bank selected by `dbg_mode_i`. When that bank is not the current one, it reads and writes the stored copy for that mode. When it is the current bank, it behaves like the main ports.
- R9: When the main write port and a debug write hit the same register in the same cycle, the main write wins.
- R10: After reset every register, in every bank, reads as zero, and the current mode is supervisor (0x13).
- R11: Changing between two codes that select the same bank (for example 0x10, 0x1F and 0x00) moves no data and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 5 | Mode code for the next cycle |
| rd_idx_i | input | 2x4 | Register index per read port |
| rd_data_o | output | 2x32 | Read data per read port |
| wr_en_i | input | 1 | Main write enable |
| wr_idx_i | input | 4 | Main write register index |
| wr_data_i | input | 32 | Main write data |
| dbg_mode_i | input | 5 | Mode whose copy the debug port addresses |
| dbg_idx_i | input | 4 | Debug register index |
| dbg_wr_en_i | input | 1 | Debug write enable |
| dbg_wr_data_i | input | 32 | Debug write data |
| dbg_rd_data_o | output | 32 | Debug read data |

## Verification
The assertions take for granted that the inputs are known after reset. They also assume that a main write and a bank change are judged against the bank held at that edge, not against `mode_i`. The stimulus keeps to this by driving every input at the falling edge and holding it through the next rising edge. The random phase draws mode codes across all 32 values, mostly from the defined set. It lets the debug port and the main write port collide on the same register often enough to reach the priority rule. Directed sequences cover the full code table, round trips through the fast-interrupt bank, writes on mode-change cycles and changes between aliased codes.

// File: rtl/bkrf_pkg.sv
package bkrf_pkg;
    localparam int MODE_W   = 5;
    localparam int IDX_W    = 4;
    localparam int NUM_REGS = 1 << IDX_W;
    localparam int HI_FIRST = 8;   // first banked register
    localparam int HI_LAST  = 14;  // last banked register
    localparam int PAIR_LO  = 13;  // first register banked by every privileged mode
    localparam int HI_CNT   = HI_LAST - HI_FIRST + 1;
    localparam int MID_CNT  = PAIR_LO - HI_FIRST;
    localparam int PAIR_CNT = HI_LAST - PAIR_LO + 1;
    localparam int PRV_CNT  = 4;   // interrupt, supervisor, abort, undefined

    typedef enum logic [2:0] {
        BANK_USR = 3'd0,
        BANK_FIQ = 3'd1,
        BANK_IRQ = 3'd2,
        BANK_SVC = 3'd3,
        BANK_ABT = 3'd4,
        BANK_UND = 3'd5,
        BANK_DUM = 3'd6
    } bank_e;

    typedef enum logic [2:0] {
        LOC_LIVE,
        LOC_USR,
        LOC_FIQ,
        LOC_PRV,
        LOC_ZERO
    } loc_e;

    function automatic bank_e mode_to_bank(input logic [MODE_W-1:0] m);
        bank_e b;
        case (m)
            5'h00, 5'h10, 5'h1F: b = BANK_USR;
            5'h01, 5'h11:        b = BANK_FIQ;
            5'h02, 5'h12:        b = BANK_IRQ;
            5'h03, 5'h13:        b = BANK_SVC;
            5'h17:               b = BANK_ABT;
            5'h1B:               b = BANK_UND;
            default:             b = BANK_DUM;
        endcase
        return b;
    endfunction

    function automatic logic is_hi(input logic [IDX_W-1:0] i);
        return (int'(i) >= HI_FIRST) && (int'(i) <= HI_LAST);
    endfunction

    function automatic logic is_prv(input bank_e b);
        return (b == BANK_IRQ) || (b == BANK_SVC) || (b == BANK_ABT) || (b == BANK_UND);
    endfunction

    function automatic logic [1:0] prv_slot(input bank_e b);
        logic [2:0] t;
        t = b - 3'd2;
        return t[1:0];
    endfunction
endpackage

// File: rtl/bkrf_mode_decode.sv
module bkrf_mode_decode
    import bkrf_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output bank_e             bank_o
);
    always_comb begin
        bank_o = mode_to_bank(mode_i);
    end
endmodule

// File: rtl/bkrf_dbg_route.sv
module bkrf_dbg_route
    import bkrf_pkg::*;
(
    input  bank_e            cur_bank_i,
    input  bank_e            tgt_bank_i,
    input  logic [IDX_W-1:0] idx_i,
    output loc_e             loc_o
);
    logic pair;

    always_comb begin
        pair = int'(idx_i) >= PAIR_LO;
        if (!is_hi(idx_i)) begin
            loc_o = LOC_LIVE;
        end else if (tgt_bank_i == cur_bank_i) begin
            loc_o = (cur_bank_i == BANK_DUM) ? LOC_ZERO : LOC_LIVE;
        end else if (tgt_bank_i == BANK_DUM) begin
            loc_o = LOC_ZERO;
        end else if (tgt_bank_i == BANK_FIQ) begin
            loc_o = LOC_FIQ;
        end else if (!pair) begin
            loc_o = ((cur_bank_i == BANK_FIQ) || (cur_bank_i == BANK_DUM)) ? LOC_USR : LOC_LIVE;
        end else if (tgt_bank_i == BANK_USR) begin
            loc_o = LOC_USR;
        end else begin
            loc_o = LOC_PRV;
        end
    end
endmodule

// File: rtl/bkrf_read_port.sv
module bkrf_read_port
    import bkrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] live_i,
    input  bank_e                           bank_i,
    input  logic [IDX_W-1:0]                idx_i,
    output logic [DATA_W-1:0]               data_o
);
    always_comb begin
        if ((bank_i == BANK_DUM) && is_hi(idx_i)) begin
            data_o = '0;
        end else begin
            data_o = live_i[idx_i];
        end
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bkrf_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter int                RD_PORTS   = 2,
    parameter logic [MODE_W-1:0] RESET_MODE = 5'h13
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic [MODE_W-1:0]                 mode_i,
    input  logic [RD_PORTS-1:0][IDX_W-1:0]    rd_idx_i,
    output logic [RD_PORTS-1:0][DATA_W-1:0]   rd_data_o,
    input  logic                              wr_en_i,
    input  logic [IDX_W-1:0]                  wr_idx_i,
    input  logic [DATA_W-1:0]                 wr_data_i,
    input  logic [MODE_W-1:0]                 dbg_mode_i,
    input  logic [IDX_W-1:0]                  dbg_idx_i,
    input  logic                              dbg_wr_en_i,
    input  logic [DATA_W-1:0]                 dbg_wr_data_i,
    output logic [DATA_W-1:0]                 dbg_rd_data_o
);
    localparam logic [IDX_W-1:0] IDX_HI0  = IDX_W'(HI_FIRST);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HI_LAST);
    localparam bank_e            RST_BANK = mode_to_bank(RESET_MODE);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0]              live;
        logic [HI_CNT-1:0][DATA_W-1:0]                usr;
        logic [HI_CNT-1:0][DATA_W-1:0]                fiq;
        logic [PRV_CNT-1:0][PAIR_CNT-1:0][DATA_W-1:0] prv;
        bank_e                                        bank;
    } state_t;

    state_t st_d, st_q;
    bank_e  nxt_bank, dbg_bank;
    loc_e   dbg_loc;
    logic [2:0] dbg_off;
    logic       dbg_pair;
    logic [1:0] dbg_slot;

    bkrf_mode_decode u_dec_mode (.mode_i(mode_i),     .bank_o(nxt_bank));
    bkrf_mode_decode u_dec_dbg  (.mode_i(dbg_mode_i), .bank_o(dbg_bank));

    bkrf_dbg_route u_route (
        .cur_bank_i (st_q.bank),
        .tgt_bank_i (dbg_bank),
        .idx_i      (dbg_idx_i),
        .loc_o      (dbg_loc)
    );

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        bkrf_read_port #(.DATA_W(DATA_W)) u_rd (
            .live_i (st_q.live),
            .bank_i (st_q.bank),
            .idx_i  (rd_idx_i[p]),
            .data_o (rd_data_o[p])
        );
    end

    always_comb begin
        dbg_off  = 3'(dbg_idx_i - IDX_HI0);
        dbg_pair = (dbg_idx_i == IDX_LAST);
        dbg_slot = prv_slot(dbg_bank);
        case (dbg_loc)
            LOC_LIVE: dbg_rd_data_o = st_q.live[dbg_idx_i];
            LOC_USR:  dbg_rd_data_o = st_q.usr[dbg_off];
            LOC_FIQ:  dbg_rd_data_o = st_q.fiq[dbg_off];
            LOC_PRV:  dbg_rd_data_o = st_q.prv[dbg_slot][dbg_pair];
            default:  dbg_rd_data_o = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;

        // debug write first so that the main port overrides it
        if (dbg_wr_en_i) begin
            case (dbg_loc)
                LOC_LIVE: st_d.live[dbg_idx_i]         = dbg_wr_data_i;
                LOC_USR:  st_d.usr[dbg_off]            = dbg_wr_data_i;
                LOC_FIQ:  st_d.fiq[dbg_off]            = dbg_wr_data_i;
                LOC_PRV:  st_d.prv[dbg_slot][dbg_pair] = dbg_wr_data_i;
                default:  ;
            endcase
        end

        if (wr_en_i && !((st_q.bank == BANK_DUM) && is_hi(wr_idx_i))) begin
            st_d.live[wr_idx_i] = wr_data_i;
        end

        // bank swap uses the values just written in the old mode
        if (nxt_bank != st_q.bank) begin
            // save outgoing bank
            if (st_q.bank == BANK_FIQ) begin
                for (int i = 0; i < HI_CNT; i++) begin
                    st_d.fiq[i] = st_d.live[HI_FIRST + i];
                end
            end else if (st_q.bank != BANK_DUM) begin
                if ((nxt_bank == BANK_FIQ) || (nxt_bank == BANK_DUM)) begin
                    for (int i = 0; i < MID_CNT; i++) begin
                        st_d.usr[i] = st_d.live[HI_FIRST + i];
                    end
                end
                for (int i = 0; i < PAIR_CNT; i++) begin
                    if (st_q.bank == BANK_USR) begin
                        st_d.usr[MID_CNT + i] = st_d.live[PAIR_LO + i];
                    end else begin
                        st_d.prv[prv_slot(st_q.bank)][i] = st_d.live[PAIR_LO + i];
                    end
                end
            end
            // load incoming bank
            if (nxt_bank == BANK_FIQ) begin
                for (int i = 0; i < HI_CNT; i++) begin
                    st_d.live[HI_FIRST + i] = st_d.fiq[i];
                end
            end else if (nxt_bank == BANK_DUM) begin
                for (int i = 0; i < HI_CNT; i++) begin
                    st_d.live[HI_FIRST + i] = '0;
                end
            end else begin
                if ((st_q.bank == BANK_FIQ) || (st_q.bank == BANK_DUM)) begin
                    for (int i = 0; i < MID_CNT; i++) begin
                        st_d.live[HI_FIRST + i] = st_d.usr[i];
                    end
                end
                for (int i = 0; i < PAIR_CNT; i++) begin
                    if (nxt_bank == BANK_USR) begin
                        st_d.live[PAIR_LO + i] = st_d.usr[MID_CNT + i];
                    end else begin
                        st_d.live[PAIR_LO + i] = st_d.prv[prv_slot(nxt_bank)][i];
                    end
                end
            end
            st_d.bank = nxt_bank;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.bank <= RST_BANK;
        end else begin
            st_q <= st_d;
        end
    end

    AST_MAIN_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (nxt_bank == st_q.bank) && !((st_q.bank == BANK_DUM) && is_hi(wr_idx_i)))
        |=> (st_q.live[$past(wr_idx_i)] == $past(wr_data_i))); // R6

    AST_SHARED_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i && !dbg_wr_en_i)
        |=> ($stable(st_q.live[HI_FIRST-1:0]) && $stable(st_q.live[NUM_REGS-1]))); // R2

    AST_SAME_BANK_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((nxt_bank == st_q.bank) && !wr_en_i && !dbg_wr_en_i) |=> $stable(st_q)); // R11

    AST_DBG_AGREES_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((dbg_bank == st_q.bank) && (dbg_idx_i == rd_idx_i[0]))
        |-> (dbg_rd_data_o == rd_data_o[0])); // R8

    AST_DUMMY_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q.bank == BANK_DUM) && is_hi(rd_idx_i[0])) |-> (rd_data_o[0] == '0)); // R5

    AST_FIQ_LEAVES_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q.bank == BANK_FIQ) && !dbg_wr_en_i) |=> $stable(st_q.usr[MID_CNT-1:0])); // R4
endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
    localparam int CLK_PERIOD = 10;
    localparam int B_USR = 0, B_FIQ = 1, B_IRQ = 2, B_SVC = 3, B_ABT = 4, B_UND = 5, B_DUM = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [4:0]        mode = 5'h13;
    logic [1:0][3:0]   rd_idx = '0;
    logic [1:0][31:0]  rd_data;
    logic              we = 1'b0;
    logic [3:0]        wi = '0;
    logic [31:0]       wd = '0;
    logic [4:0]        dm = 5'h13;
    logic [3:0]        di = '0;
    logic              dwe = 1'b0;
    logic [31:0]       dwd = '0;
    logic [31:0]       drd;

    int    checks = 0;
    int    errors = 0;
    string phase = "R10";
    int    cur = B_SVC;
    logic [31:0] msh [16];
    logic [31:0] mbk [7][16];

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_regfile u_dut (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
        .rd_idx_i(rd_idx), .rd_data_o(rd_data),
        .wr_en_i(we), .wr_idx_i(wi), .wr_data_i(wd),
        .dbg_mode_i(dm), .dbg_idx_i(di), .dbg_wr_en_i(dwe),
        .dbg_wr_data_i(dwd), .dbg_rd_data_o(drd)
    );

    // R1 code table
    function automatic int bank_of(input logic [4:0] m);
        case (m)
            5'h10, 5'h00, 5'h1F: return B_USR;
            5'h11, 5'h01:        return B_FIQ;
            5'h12, 5'h02:        return B_IRQ;
            5'h13, 5'h03:        return B_SVC;
            5'h17:               return B_ABT;
            5'h1B:               return B_UND;
            default:             return B_DUM;
        endcase
    endfunction

    function automatic int owner(input int b, input int i);
        if (b == B_FIQ) return B_FIQ;
        if (i <= 12) return B_USR;
        return b;
    endfunction

    function automatic logic [31:0] mread(input int b, input int i);
        if (i < 8 || i == 15) return msh[i];
        if (b == B_DUM) return '0;
        return mbk[owner(b, i)][i];
    endfunction

    function automatic void mwrite(input int b, input int i, input logic [31:0] v);
        if (i < 8 || i == 15) msh[i] = v;
        else if (b != B_DUM) mbk[owner(b, i)][i] = v;
    endfunction

    function automatic string tag_for(input int b, input int i);
        if (i < 8 || i == 15) return "R2";
        if (b == B_DUM) return "R5";
        if (b != B_FIQ && i <= 12) return "R4";
        return "R3";
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s [%s] %s got %h exp %h", req, phase, what, got, exp);
        end
    endtask

    task automatic cyc(input logic [4:0] m, input logic w, input int wix, input logic [31:0] wv,
                       input int r0, input int r1, input logic [4:0] dmode, input int dix,
                       input logic dw, input logic [31:0] dv);
        int db;
        @(negedge clk);
        mode = m; we = w; wi = 4'(wix); wd = wv;
        rd_idx[0] = 4'(r0); rd_idx[1] = 4'(r1);
        dm = dmode; di = 4'(dix); dwe = dw; dwd = dv;
        #1;
        db = bank_of(dmode);
        chk(tag_for(cur, r0), "rd0", rd_data[0], mread(cur, r0));
        chk(tag_for(cur, r1), "rd1", rd_data[1], mread(cur, r1));
        chk((db != cur) ? "R8" : tag_for(cur, dix), "dbg", drd, mread(db, dix));
        @(posedge clk);
        if (dw) mwrite(db, dix, dv);   // R9: main write applied after, so it wins
        if (w) mwrite(cur, wix, wv);   // R7: old mode's set
        cur = bank_of(m);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 16; i++) begin
            msh[i] = '0;
            for (int b = 0; b < 7; b++) mbk[b][i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: everything zero after reset, supervisor current
        phase = "R10";
        for (int i = 0; i < 16; i++) cyc(5'h13, 0, 0, 0, i, 15 - i, 5'h11, i, 0, 0);
        for (int i = 0; i < 16; i++) cyc(5'h13, 0, 0, 0, i, i, 5'h10, i, 0, 0);

        // R2: fill every register in supervisor mode
        phase = "R2";
        for (int i = 0; i < 16; i++) cyc(5'h13, 1, i, 32'h5000_0000 + i, i, 0, 5'h13, i, 0, 0);
        for (int i = 0; i < 16; i++) cyc(5'h13, 0, 0, 0, i, 0, 5'h12, i, 0, 0);

        // R1: walk every code, writing r13 each cycle
        phase = "R1";
        for (int c = 0; c < 32; c++) cyc(5'(c), 1, 13, 32'hA000_0000 + c, 13, 14, 5'(c), 13, 0, 0);
        for (int c = 0; c < 32; c++) cyc(5'h13, 0, 0, 0, 13, 8, 5'(c), 13, 0, 0);

        // R4/R3: user r8-r12 survive a stay in fast-interrupt mode
        phase = "R4";
        cyc(5'h10, 0, 0, 0, 8, 9, 5'h10, 10, 0, 0);
        for (int i = 8; i <= 14; i++) cyc(5'h10, 1, i, 32'hC000_0000 + i, i, i, 5'h11, i, 0, 0);
        cyc(5'h11, 0, 0, 0, 8, 12, 5'h10, 8, 0, 0);
        for (int i = 8; i <= 14; i++) cyc(5'h11, 1, i, 32'hF000_0000 + i, i, 8, 5'h10, i, 0, 0);
        cyc(5'h10, 0, 0, 0, 8, 14, 5'h11, 8, 0, 0);
        for (int i = 8; i <= 14; i++) cyc(5'h10, 0, 0, 0, i, 15, 5'h11, i, 0, 0);

        // R5: dummy bank reads zero and drops writes
        phase = "R5";
        cyc(5'h05, 0, 0, 0, 8, 13, 5'h10, 8, 0, 0);
        for (int i = 8; i <= 14; i++) cyc(5'h05, 1, i, 32'hDEAD_0000 + i, i, 3, 5'h05, i, 1, 32'h1234_5678);
        cyc(5'h10, 0, 0, 0, 8, 12, 5'h05, 9, 0, 0);
        for (int i = 8; i <= 14; i++) cyc(5'h10, 0, 0, 0, i, 0, 5'h1F, i, 0, 0);

        // R6: same-cycle read of written register
        phase = "R6";
        for (int i = 0; i < 16; i++) cyc(5'h10, 1, i, 32'h6600_0000 + i, i, i, 5'h10, i, 0, 0);
        cyc(5'h10, 0, 0, 0, 0, 15, 5'h10, 5, 0, 0);

        // R7: write on a mode change cycle
        phase = "R7";
        cyc(5'h12, 1, 13, 32'h7777_0013, 13, 14, 5'h12, 13, 0, 0);
        cyc(5'h11, 1, 9, 32'h7777_0009, 9, 13, 5'h10, 13, 0, 0);
        cyc(5'h1B, 1, 14, 32'h7777_0014, 9, 14, 5'h10, 9, 0, 0);
        cyc(5'h1B, 0, 0, 0, 14, 9, 5'h11, 14, 0, 0);

        // R9: debug and main write collide
        phase = "R9";
        cyc(5'h1B, 1, 4, 32'h9999_0001, 4, 4, 5'h1B, 4, 1, 32'h9999_0002);
        cyc(5'h1B, 1, 13, 32'h9999_0003, 4, 13, 5'h17, 13, 1, 32'h9999_0004);
        cyc(5'h1B, 0, 0, 0, 13, 4, 5'h17, 13, 0, 0);

        // R11: aliased codes
        phase = "R11";
        cyc(5'h10, 1, 13, 32'hB0B0_0013, 13, 8, 5'h10, 14, 0, 0);
        cyc(5'h1F, 0, 0, 0, 13, 8, 5'h13, 13, 0, 0);
        cyc(5'h00, 0, 0, 0, 13, 14, 5'h1F, 13, 0, 0);
        cyc(5'h03, 0, 0, 0, 13, 14, 5'h00, 13, 0, 0);
        cyc(5'h13, 0, 0, 0, 13, 14, 5'h10, 13, 0, 0);

        // random
        phase = "RND";
        begin
            logic [4:0] good [11] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h00, 5'h01, 5'h02, 5'h03};
            logic [4:0] m = 5'h13;
            for (int k = 0; k < 4000; k++) begin
                logic [4:0] dmr;
                if ($urandom % 4 == 0) m = ($urandom % 10 < 8) ? good[$urandom % 11] : 5'($urandom);
                dmr = ($urandom % 10 < 8) ? good[$urandom % 11] : 5'($urandom);
                cyc(m, 1'($urandom), int'($urandom % 16), $urandom,
                    int'($urandom % 16), int'($urandom % 16), dmr, int'($urandom % 16),
                    ($urandom % 3 == 0), $urandom);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule